// File: doc/BRIEF.md
# Serial Address-Match Wake-Up Controller

This block sits beside a serial shift engine and supplies its control and wake-up logic. A CPU-side port writes an 8-bit control register, either as a whole byte or one bit at a time. The register holds the enable, wake-up, transfer-mode and clock-source fields. The block compares a programmable slave address with the byte the shift engine has received. It reports the result in a read-only flag inside the control image.

The block gates the engine's end-of-transfer strobe into an interrupt. With wake-up armed in the two-wire bus mode, only an address byte that follows a start condition and matches the slave address raises it. It also gates CPU writes to the shift register, which are refused while wake-up is armed. It selects one of three serial clock sources, given as single-cycle tick enables in the block's clock domain. In bus mode the timer source is divided by 16.

Top module: `sadr_wake_ctrl`

## Requirements
- R1: After reset the control image reads 0x00, the slave address is 0x00, both error flags are 0, and `irq` and `ser_tick` are 0.
- R2: Control image layout: bit 7 is enable, bit 6 is the read-only compare flag, bit 5 is wake-up, bits 4:2 are mode, and bits 1:0 are clock select. A write to bit 6 has no effect on what bit 6 reads.
- R3: Bit 6 reads 1 exactly when enable is 1 and the slave address equals `rx_byte`. It reads 0 whenever enable is 0.
- R4: With `ctrl_bit_mode`=1, a write changes only bit `ctrl_bit_idx`, to the value of `ctrl_wdata[0]`.
- R5: While enabled, with wake-up at 0 or in three-wire mode, `irq` is high in the same cycle as every `xfer_done` strobe and low otherwise.
- R6: While enabled in bus mode with wake-up at 1, `irq` follows `xfer_done` only when `cmd_det` is 1 and the compare flag is 1.
- R7: While enable is 0, `irq` and `ser_tick` stay 0.
- R8: Clock select 0x (bits 1:0 = 00 or 01) passes `sck_ext_tick`. Select 10 passes `tmr_tick`. Select 11 passes `pre_tick`.
- R9: In bus mode with select 10, `ser_tick` fires only on every 16th `tmr_tick`. The tick counter restarts from zero after enable has been 0.
- R10: Mode bits 4:3 = 11 select bus mode (`bus_mode`=1, MSB first). Any other value selects three-wire mode, where bit 2 = 0 means MSB first and bit 2 = 1 means LSB first.
- R11: While wake-up is 1, `shift_wr_req` is not forwarded on `shift_wr_ok` and sets sticky `err_flags[1]`. Otherwise it is forwarded in the same cycle.
- R12: A write that keeps enable at 1 while enable is already 1 and changes mode bits keeps the old mode and sets sticky `err_flags[0]`. Its other fields are taken. A write that clears enable may change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_bit_mode | input | 1 | 1: single-bit write, 0: byte write |
| ctrl_bit_idx | input | 3 | Bit addressed by a single-bit write |
| ctrl_wdata | input | 8 | Write data (bit 0 used in single-bit writes) |
| ctrl_rd | output | 8 | Control image including compare flag |
| sva_we | input | 1 | Slave address write strobe |
| sva_wdata | input | ADDR_W | Slave address write data |
| shift_wr_req | input | 1 | CPU request to write the shift register |
| shift_wr_ok | output | 1 | Forwarded shift register write strobe |
| xfer_done | input | 1 | End-of-transfer strobe from the shift engine |
| cmd_det | input | 1 | Byte follows a detected start condition |
| rx_byte | input | ADDR_W | Current shift register contents |
| sck_ext_tick | input | 1 | External serial clock tick |
| tmr_tick | input | 1 | Timer output tick |
| pre_tick | input | 1 | Prescaler clock tick |
| ser_tick | output | 1 | Selected serial clock tick |
| bus_mode | output | 1 | Two-wire bus mode active |
| msb_first | output | 1 | Shift order, 1 = MSB first |
| irq | output | 1 | Transfer interrupt pulse |
| err_flags | output | 2 | Sticky: [0] rejected mode change, [1] refused shift write |

## Verification
The hardest condition to reach is a rejected mode change. The bench must first reach an enabled state in one mode, which takes a disabled write followed by an enabling write. It then issues byte writes and single-bit writes that keep enable set while altering the mode. It checks that the old mode survives, and that a later write clearing enable changes the mode. The divide-by-16 restart is reached in a similar way. The bench pulses the timer tick part way through a count, drops enable, re-enables, and counts the full 16 ticks again.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam int CTRL_W   = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_CMP  = 6;
  localparam int BIT_WUP  = 5;
  localparam int MODE_HI  = 4;
  localparam int MODE_LO  = 2;
  localparam int MODE_W   = MODE_HI - MODE_LO + 1;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_EXT_A = 2'b00,
    SRC_EXT_B = 2'b01,
    SRC_TMR   = 2'b10,
    SRC_PRE   = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic              en;
    logic              wup;
    logic [MODE_W-1:0] mode;
    logic [SEL_W-1:0]  sel;
  } ctrl_t;
endpackage

// File: rtl/swk_ctrl_reg.sv
module swk_ctrl_reg
  import swk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              bit_mode,
  input  logic [2:0]        bit_idx,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              mode_err
);
  ctrl_t             ctrl_q, ctrl_d, cand;
  logic              err_q, err_d;
  logic [CTRL_W-1:0] image, merged;
  logic              reject;
  logic              unused_cmp_bit;

  always_comb begin
    image = '0;
    image[BIT_EN]              = ctrl_q.en;
    image[BIT_WUP]             = ctrl_q.wup;
    image[MODE_HI:MODE_LO]     = ctrl_q.mode;
    image[SEL_W-1:0]           = ctrl_q.sel;
    merged = image;
    if (bit_mode) merged[bit_idx] = wdata[0];
    else          merged = wdata;
  end

  assign unused_cmp_bit = merged[BIT_CMP];

  always_comb begin
    cand.en   = merged[BIT_EN];
    cand.wup  = merged[BIT_WUP];
    cand.mode = merged[MODE_HI:MODE_LO];
    cand.sel  = merged[SEL_W-1:0];
    reject    = we & ctrl_q.en & cand.en & (cand.mode != ctrl_q.mode);
    if (reject) cand.mode = ctrl_q.mode;
    ctrl_d = we ? cand : ctrl_q;
    err_d  = err_q | reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign mode_err = err_q;
endmodule

// File: rtl/swk_addr_cmp.sv
module swk_addr_cmp #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sva_we,
  input  logic [ADDR_W-1:0] sva_wdata,
  input  logic [ADDR_W-1:0] rx_byte,
  output logic              match
);
  logic [ADDR_W-1:0] sva_q, sva_d;

  always_comb begin
    sva_d = sva_we ? sva_wdata : sva_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sva_q <= '0;
    else        sva_q <= sva_d;
  end

  assign match = en & (sva_q == rx_byte);
endmodule

// File: rtl/swk_wake_gate.sv
module swk_wake_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wup,
  input  logic bus_mode,
  input  logic match,
  input  logic xfer_done,
  input  logic cmd_det,
  input  logic shift_wr_req,
  output logic irq,
  output logic shift_wr_ok,
  output logic shift_err
);
  logic wake_armed, addr_hit;
  logic err_q, err_d;

  always_comb begin
    wake_armed  = wup & bus_mode;
    addr_hit    = cmd_det & match;
    irq         = en & xfer_done & (~wake_armed | addr_hit);
    shift_wr_ok = shift_wr_req & ~wup;
    err_d       = err_q | (shift_wr_req & wup);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign shift_err = err_q;
endmodule

// File: rtl/swk_clk_sel.sv
module swk_clk_sel
  import swk_pkg::*;
#(
  parameter int DIV_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bus_mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_tick,
  input  logic             tmr_tick,
  input  logic             pre_tick,
  output logic             ser_tick
);
  localparam logic [DIV_LOG2-1:0] CNT_LAST = '1;

  logic [DIV_LOG2-1:0] cnt_q, cnt_d;
  logic                div_on, cnt_step, raw_tick;

  always_comb begin
    div_on   = bus_mode & (clk_src_e'(sel) == SRC_TMR);
    cnt_step = en & div_on & tmr_tick;
    cnt_d    = cnt_q;
    if (!en)           cnt_d = '0;
    else if (cnt_step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    unique case (clk_src_e'(sel))
      SRC_EXT_A, SRC_EXT_B: raw_tick = ext_tick;
      SRC_TMR:   raw_tick = div_on ? (tmr_tick & (cnt_q == CNT_LAST)) : tmr_tick;
      default:   raw_tick = pre_tick;
    endcase
    ser_tick = en & raw_tick;
  end
endmodule

// File: rtl/sadr_wake_ctrl.sv
module sadr_wake_ctrl
  import swk_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DIV_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ctrl_bit_mode,
  input  logic [2:0]        ctrl_bit_idx,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rd,
  input  logic              sva_we,
  input  logic [ADDR_W-1:0] sva_wdata,
  input  logic              shift_wr_req,
  output logic              shift_wr_ok,
  input  logic              xfer_done,
  input  logic              cmd_det,
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic              sck_ext_tick,
  input  logic              tmr_tick,
  input  logic              pre_tick,
  output logic              ser_tick,
  output logic              bus_mode,
  output logic              msb_first,
  output logic              irq,
  output logic [1:0]        err_flags
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  ctrl_t      ctrl;
  logic       match, mode_err, shift_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  swk_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (ctrl_we),
    .bit_mode (ctrl_bit_mode),
    .bit_idx  (ctrl_bit_idx),
    .wdata    (ctrl_wdata),
    .ctrl     (ctrl),
    .mode_err (mode_err)
  );

  always_comb begin
    bus_mode  = ctrl.mode[2] & ctrl.mode[1];
    msb_first = bus_mode | ~ctrl.mode[0];
  end

  swk_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (ctrl.en),
    .sva_we    (sva_we),
    .sva_wdata (sva_wdata),
    .rx_byte   (rx_byte),
    .match     (match)
  );

  swk_wake_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en           (ctrl.en),
    .wup          (ctrl.wup),
    .bus_mode     (bus_mode),
    .match        (match),
    .xfer_done    (xfer_done),
    .cmd_det      (cmd_det),
    .shift_wr_req (shift_wr_req),
    .irq          (irq),
    .shift_wr_ok  (shift_wr_ok),
    .shift_err    (shift_err)
  );

  swk_clk_sel #(.DIV_LOG2(DIV_LOG2)) u_clk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (ctrl.en),
    .bus_mode (bus_mode),
    .sel      (ctrl.sel),
    .ext_tick (sck_ext_tick),
    .tmr_tick (tmr_tick),
    .pre_tick (pre_tick),
    .ser_tick (ser_tick)
  );

  assign ctrl_rd   = {ctrl.en, match, ctrl.wup, ctrl.mode, ctrl.sel};
  assign err_flags = {shift_err, mode_err};
endmodule

// File: rtl/sadr_wake_ctrl_chk.sv
module sadr_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_rd,
  input logic       shift_wr_req,
  input logic       shift_wr_ok,
  input logic       xfer_done,
  input logic       cmd_det,
  input logic       ser_tick,
  input logic       bus_mode,
  input logic       irq,
  input logic [1:0] err_flags
);
  AST_CMP_OFF_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[7] |-> !ctrl_rd[6]); // R3
  AST_IRQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (xfer_done && ctrl_rd[7])); // R5
  AST_WAKE_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ctrl_rd[5] && bus_mode) |-> (cmd_det && ctrl_rd[6])); // R6
  AST_QUIET_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[7] |-> (!irq && !ser_tick)); // R7
  AST_SHIFT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr_req && ctrl_rd[5]) |-> !shift_wr_ok); // R11
  AST_SHIFT_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr_req && ctrl_rd[5]) |=> err_flags[1]); // R11
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[7] |=> (!ctrl_rd[7] || ctrl_rd[4:2] == $past(ctrl_rd[4:2]))); // R12
  AST_MODE_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flags[0] |=> err_flags[0]); // R12
endmodule

bind sadr_wake_ctrl sadr_wake_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_rd      (ctrl_rd),
  .shift_wr_req (shift_wr_req),
  .shift_wr_ok  (shift_wr_ok),
  .xfer_done    (xfer_done),
  .cmd_det      (cmd_det),
  .ser_tick     (ser_tick),
  .bus_mode     (bus_mode),
  .irq          (irq),
  .err_flags    (err_flags)
);

// File: tb/sadr_wake_ctrl_bench.sv
module sadr_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {ctrl byte, slave addr, rx byte, cmd_det, expected irq, expected compare flag}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h80, 8'h55, 8'h55, 1'b0, 1'b1, 1'b1},
    {8'h80, 8'h55, 8'h54, 1'b0, 1'b1, 1'b0},
    {8'h98, 8'h3A, 8'h3A, 1'b1, 1'b1, 1'b1},
    {8'hB8, 8'h3A, 8'h3A, 1'b1, 1'b1, 1'b1},
    {8'hB8, 8'h3A, 8'h3B, 1'b1, 1'b0, 1'b0},
    {8'hB8, 8'h3A, 8'h3A, 1'b0, 1'b0, 1'b1},
    {8'hA0, 8'h3A, 8'h00, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h11, 8'h11, 1'b0, 1'b0, 1'b0},
    {8'h38, 8'h11, 8'h11, 1'b1, 1'b0, 1'b0}
  };

  logic       clk, rst_n;
  logic       ctrl_we, ctrl_bit_mode;
  logic [2:0] ctrl_bit_idx;
  logic [7:0] ctrl_wdata, ctrl_rd;
  logic       sva_we;
  logic [7:0] sva_wdata, rx_byte;
  logic       shift_wr_req, shift_wr_ok, xfer_done, cmd_det;
  logic       sck_ext_tick, tmr_tick, pre_tick, ser_tick;
  logic       bus_mode, msb_first, irq;
  logic [1:0] err_flags;
  int         n_chk, n_fail;
  logic       done;

  sadr_wake_ctrl u_sadr_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_bit_mode(ctrl_bit_mode),
    .ctrl_bit_idx(ctrl_bit_idx), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
    .sva_we(sva_we), .sva_wdata(sva_wdata), .shift_wr_req(shift_wr_req),
    .shift_wr_ok(shift_wr_ok), .xfer_done(xfer_done), .cmd_det(cmd_det),
    .rx_byte(rx_byte), .sck_ext_tick(sck_ext_tick), .tmr_tick(tmr_tick),
    .pre_tick(pre_tick), .ser_tick(ser_tick), .bus_mode(bus_mode),
    .msb_first(msb_first), .irq(irq), .err_flags(err_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_bit_mode = 1'b0; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] idx, input logic v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_bit_mode = 1'b1; ctrl_bit_idx = idx; ctrl_wdata = {7'd0, v};
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_bit_mode = 1'b0;
  endtask

  task automatic wr_sva(input logic [7:0] d);
    @(negedge clk);
    sva_we = 1'b1; sva_wdata = d;
    @(negedge clk);
    sva_we = 1'b0;
  endtask

  task automatic tmr_pulse(output logic seen);
    @(negedge clk);
    tmr_tick = 1'b1;
    #1 seen = ser_tick;
    @(negedge clk);
    tmr_tick = 1'b0;
  endtask

  task automatic div_run(input string req);
    logic seen;
    int   early;
    early = 0;
    for (int k = 1; k < 16; k++) begin
      tmr_pulse(seen);
      if (seen) early++;
    end
    check(req, early, 0);
    tmr_pulse(seen);
    check(req, {31'd0, seen}, 1);
  endtask

  initial begin
    done = 1'b0;
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic seen;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    ctrl_we = 0; ctrl_bit_mode = 0; ctrl_bit_idx = 0; ctrl_wdata = 0;
    sva_we = 0; sva_wdata = 0; rx_byte = 8'h01; shift_wr_req = 0;
    xfer_done = 0; cmd_det = 0; sck_ext_tick = 0; tmr_tick = 0; pre_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ctrl", ctrl_rd, 8'h00);
    check("R1 err", err_flags, 0);
    check("R1 irq/tick", {irq, ser_tick}, 0);
    rx_byte = 8'h00;
    wr_byte(8'h80);
    check("R1 slave addr zero", ctrl_rd[6], 1);
    wr_byte(8'h00);

    // Vector table: R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] c, s, r;
      logic cd, ei, ec;
      {c, s, r, cd, ei, ec} = VEC[i];
      wr_byte(8'h00);
      wr_sva(s);
      wr_byte(c);
      rx_byte = r; cmd_det = cd; xfer_done = 1'b0;
      #1 check("R5 no strobe no irq", irq, 0);
      xfer_done = 1'b1;
      #1 check("R5/R6/R7 irq", irq, ei);
      check("R3 compare flag", ctrl_rd[6], ec);
      @(negedge clk);
      xfer_done = 1'b0; cmd_det = 1'b0;
    end

    // R2 bit 6 write ignored; R12 mode change rejection; R4 bit writes
    wr_sva(8'hA5); rx_byte = 8'h00;
    wr_byte(8'h00);
    wr_byte(8'hC0);
    check("R2 bit6 write ignored", ctrl_rd, 8'h80);
    check("R12 no error yet", err_flags[0], 0);
    wr_byte(8'h98);
    check("R12 mode kept", ctrl_rd, 8'h80);
    check("R12 sticky error", err_flags[0], 1);
    wr_byte(8'h18);
    check("R12 disable write accepted", ctrl_rd, 8'h18);
    wr_bit(3'd7, 1'b1);
    check("R4 bit write enable", ctrl_rd, 8'h98);
    wr_bit(3'd3, 1'b0);
    check("R12 bit write mode rejected", ctrl_rd, 8'h98);
    wr_bit(3'd5, 1'b1);
    check("R4 bit write wake", ctrl_rd, 8'hB8);
    wr_bit(3'd6, 1'b1);
    check("R2 bit6 bit write ignored", ctrl_rd, 8'hB8);
    wr_bit(3'd5, 1'b0);
    check("R4 bit write clear", ctrl_rd, 8'h98);

    // R10 mode decode
    wr_byte(8'h00); wr_byte(8'h84);
    check("R10 3-wire LSB", {bus_mode, msb_first}, 2'b00);
    wr_byte(8'h00); wr_byte(8'h80);
    check("R10 3-wire MSB", {bus_mode, msb_first}, 2'b01);
    wr_byte(8'h00); wr_byte(8'h9C);
    check("R10 bus mode", {bus_mode, msb_first}, 2'b11);

    // R11 shift write gating
    wr_byte(8'h00); wr_byte(8'h80);
    @(negedge clk); shift_wr_req = 1'b1;
    #1 check("R11 forwarded", shift_wr_ok, 1);
    @(negedge clk); shift_wr_req = 1'b0;
    check("R11 no error", err_flags[1], 0);
    wr_byte(8'hA0);
    @(negedge clk); shift_wr_req = 1'b1;
    #1 check("R11 blocked", shift_wr_ok, 0);
    @(negedge clk); shift_wr_req = 1'b0;
    check("R11 error set", err_flags[1], 1);

    // R8 clock select
    wr_byte(8'h00); wr_byte(8'h80);
    @(negedge clk); sck_ext_tick = 1'b1;
    #1 check("R8 ext", ser_tick, 1);
    sck_ext_tick = 1'b0; tmr_tick = 1'b1;
    #1 check("R8 ext ignores timer", ser_tick, 0);
    tmr_tick = 1'b0;
    wr_byte(8'h82);
    tmr_pulse(seen);
    check("R8 timer undivided in 3-wire", seen, 1);
    wr_byte(8'h83);
    @(negedge clk); pre_tick = 1'b1;
    #1 check("R8 prescaler", ser_tick, 1);
    pre_tick = 1'b0; sck_ext_tick = 1'b1;
    #1 check("R8 prescaler ignores ext", ser_tick, 0);
    sck_ext_tick = 1'b0;

    // R9 divide by 16 and restart; R7 tick gated when disabled
    wr_byte(8'h00); wr_byte(8'h9A);
    div_run("R9 divide");
    for (int k = 0; k < 5; k++) tmr_pulse(seen);
    wr_byte(8'h1A);
    @(negedge clk); sck_ext_tick = 1'b1; tmr_tick = 1'b1; pre_tick = 1'b1;
    #1 check("R7 tick off when disabled", ser_tick, 0);
    @(negedge clk); sck_ext_tick = 1'b0; tmr_tick = 1'b0; pre_tick = 1'b0;
    wr_byte(8'h9A);
    div_run("R9 restart");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule